// File: doc/BRIEF.md
# Platform Interrupt Claim Arbiter

This block is the selection core of a platform-level interrupt controller. A parameterised number of interrupt sources each drive a level input, and a parameterised number of contexts each hold a threshold and a per-source enable mask. For every context, the block continuously finds the best eligible source. A source is eligible when it is pending, is not already being serviced, and is enabled for that context. The best source is the one with the highest priority that is strictly above the context threshold. A context with a winner raises its interrupt request. That request is routed to either the machine-mode or the supervisor-mode external interrupt line of one hart.

A register decoder outside this block drives the configuration ports, which set source priorities, context thresholds and enable words. The decoder also drives a claim strobe and a completion strobe. A claim returns the winning ID for the addressed context in the same cycle and marks that source as in service. A later completion carrying the same ID releases the source for selection again.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is a candidate for a context only when its pending bit is 1, its in-service bit is 0 and its enable bit for that context is 1.
- R2: A candidate wins only if its priority is strictly greater than the context threshold; a source whose priority equals the threshold never raises the context.
- R3: Among candidates of equal top priority the lowest source ID wins. Source ID 0 is never selected, and a context with no candidate reports ID 0 with its request low.
- R4: The pending bit of source i follows its level input, registered at each clock edge: high sets it, low clears it.
- R5: Context c drives `m_irq[h]` when its mode bit `CTX_MODE[c]` is 1, or `s_irq[h]` when it is 0, where h = `CTX_HART[c]` − `HART_BASE`. Each line is the OR of the requests of the contexts mapped to it. `ctx_irq[c]` is high exactly when context c has a winner.
- R6: While `claim_req` is high, `claim_id` shows the winner of context `claim_ctx`. At the clock edge that winner's in-service bit is set and its pending bit is cleared, so all contexts re-select from the next cycle.
- R7: A completion with `done_id` below `NSRC` clears that source's in-service bit at the clock edge. A completion with `done_id` ≥ `NSRC` changes nothing.
- R8: Synchronous active-low reset clears all priorities, thresholds, enables, pending and in-service bits, so every ID reads 0 and every interrupt line is low.
- R9: The enable mask of a context is written one 32-bit word at a time. Word k bit j enables source 32·k + j. In the last word only the bits of existing sources are kept.
- R10: Writing a priority to a source index ≥ `NSRC` changes no stored priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NSRC | Level request per source (bit 0 unused) |
| prio_we | input | 1 | Priority write strobe |
| prio_src | input | IDW | Source whose priority is written |
| prio_val | input | PRIO_W | New priority |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTXW | Context whose threshold is written |
| thr_val | input | PRIO_W | New threshold |
| en_we | input | 1 | Enable word write strobe |
| en_ctx | input | CTXW | Context whose enable word is written |
| en_word | input | WDW | Index of the 32-bit enable word |
| en_data | input | 32 | Enable bits for the word |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CTXW | Context being claimed or inspected |
| claim_id | output | IDW | Current winner of `claim_ctx` (0 = none) |
| done_we | input | 1 | Completion strobe |
| done_id | input | 32 | Source ID being completed |
| ctx_irq | output | NCTX | Per-context interrupt request |
| m_irq | output | NHART | Machine-mode external interrupt per hart |
| s_irq | output | NHART | Supervisor-mode external interrupt per hart |

## Verification
Every stored piece of state is registered, and the selection and routing after it are combinational. A configuration write, a level change, a claim or a completion applied before a clock edge therefore shows on `claim_id`, `ctx_irq`, `m_irq` and `s_irq` after that single edge. The one exception is the ID returned during a claim, which is due in the claim cycle itself. The bench drives each stimulus just after a falling edge and keeps it for one full cycle. It checks the results after the next falling edge, and it reads the claim ID in the middle of the claim cycle. For each context it steps `claim_ctx` through the contexts between edges, and it compares against a model that tracks the same state one edge at a time.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants and helpers for the interrupt claim arbiter.
// Assumes enable state is organised in 32-bit words.
package irq_arb_pkg;
    localparam int ENW = 32;

    typedef enum logic {
        CTX_SUPERVISOR = 1'b0,
        CTX_MACHINE    = 1'b1
    } ctx_mode_e;

    // Number of 32-bit words needed to hold n bits.
    function automatic int words_for(input int n);
        return (n + ENW - 1) / ENW;
    endfunction
endpackage

// File: rtl/irq_src_state.sv
// Module: per-source state (priority, pending, in-service).
// Pending follows the level input each cycle; a claim clears the winner's
// pending bit and sets its in-service bit; a completion below NSRC releases it.
// Assumes claim_win is a valid source ID whenever claim_fire is high.
module irq_src_state #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3,
    parameter int IDW    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_level,
    input  logic              prio_we,
    input  logic [IDW-1:0]    prio_src,
    input  logic [PRIO_W-1:0] prio_val,
    input  logic              claim_fire,
    input  logic [IDW-1:0]    claim_win,
    input  logic              done_we,
    input  logic [31:0]       done_id,
    output logic [NSRC-1:0]   pend_q,
    output logic [NSRC-1:0]   busy_q,
    output logic [PRIO_W-1:0] prio_q [NSRC]
);
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] busy_d;
    logic            done_ok;

    assign done_ok = done_we && (done_id < 32'(NSRC));

    // Next pending: sample levels, source 0 never pends, claimed winner drops.
    always_comb begin
        pend_d    = src_level;
        pend_d[0] = 1'b0;
        if (claim_fire) pend_d[claim_win] = 1'b0;
    end

    // Next in-service: completion releases first, then a claim sets.
    always_comb begin
        busy_d = busy_q;
        if (done_ok) busy_d[done_id[IDW-1:0]] = 1'b0;
        if (claim_fire) busy_d[claim_win] = 1'b1;
    end

    // Pending and in-service registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            busy_q <= '0;
        end else begin
            pend_q <= pend_d;
            busy_q <= busy_d;
        end
    end

    // Priority registers, writes to nonexistent sources dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
        end else if (prio_we && (int'(prio_src) < NSRC)) begin
            prio_q[prio_src] <= prio_val;
        end
    end

    // R6
    claim_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> (busy_q[$past(claim_win)] && !pend_q[$past(claim_win)]));
    // R7
    bad_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_we && done_id >= 32'(NSRC) && !claim_fire) |=> $stable(busy_q));
    // R4
    src0_never_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !pend_q[0]);
endmodule

// File: rtl/irq_ctx_cfg.sv
// Module: per-context threshold and enable storage.
// Enables are written one 32-bit word at a time; only bits that map to an
// existing source are stored. Assumes NCTX and word indices come pre-decoded.
module irq_ctx_cfg #(
    parameter int NSRC   = 40,
    parameter int NCTX   = 4,
    parameter int PRIO_W = 3,
    parameter int CTXW   = 2,
    parameter int WDW    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_we,
    input  logic [CTXW-1:0]   thr_ctx,
    input  logic [PRIO_W-1:0] thr_val,
    input  logic              en_we,
    input  logic [CTXW-1:0]   en_ctx,
    input  logic [WDW-1:0]    en_word,
    input  logic [31:0]       en_data,
    output logic [PRIO_W-1:0] thr_q [NCTX],
    output logic [NSRC-1:0]   en_q [NCTX]
);
    import irq_arb_pkg::*;

    // Threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) thr_q[c] <= '0;
        end else if (thr_we && (int'(thr_ctx) < NCTX)) begin
            thr_q[thr_ctx] <= thr_val;
        end
    end

    // Enable registers, one word slice per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) en_q[c] <= '0;
        end else if (en_we && (int'(en_ctx) < NCTX)) begin
            for (int b = 0; b < NSRC; b++) begin
                if ((b / ENW) == int'(en_word)) en_q[en_ctx][b] <= en_data[b % ENW];
            end
        end
    end
endmodule

// File: rtl/irq_ctx_select.sv
// Module: best-source search for one context.
// Starts from the threshold and accepts a candidate only on a strictly higher
// priority, scanning upward so ties keep the lowest ID. Source 0 is skipped.
// Purely combinational; clk and rst_n serve the assertions.
module irq_ctx_select #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3,
    parameter int IDW    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   busy,
    input  logic [NSRC-1:0]   en,
    input  logic [PRIO_W-1:0] prio [NSRC],
    input  logic [PRIO_W-1:0] thr,
    output logic [IDW-1:0]    win_id
);
    logic [PRIO_W-1:0] best;

    // Linear max search with strict comparison.
    always_comb begin
        best   = thr;
        win_id = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (pend[i] && !busy[i] && en[i] && (prio[i] > best)) begin
                best   = prio[i];
                win_id = IDW'(i);
            end
        end
    end

    // R1
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> (pend[win_id] && !busy[win_id] && en[win_id]));
    // R2
    winner_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> (prio[win_id] > thr));
endmodule

// File: rtl/irq_route.sv
// Module: maps context requests onto per-hart machine/supervisor lines.
// Assumes every CTX_HART entry lies in HART_BASE .. HART_BASE+NHART-1.
module irq_route #(
    parameter int          NCTX      = 4,
    parameter int          NHART     = 2,
    parameter int          HART_BASE = 2,
    parameter int          CTX_HART [NCTX] = '{default: 0},
    parameter logic [NCTX-1:0] CTX_MODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCTX-1:0]  ctx_irq,
    output logic [NHART-1:0] m_irq,
    output logic [NHART-1:0] s_irq
);
    import irq_arb_pkg::*;

    // OR each context's request into its hart's mode line.
    always_comb begin
        m_irq = '0;
        s_irq = '0;
        for (int c = 0; c < NCTX; c++) begin
            for (int h = 0; h < NHART; h++) begin
                if (CTX_HART[c] - HART_BASE == h) begin
                    if (ctx_mode_e'(CTX_MODE[c]) == CTX_MACHINE) m_irq[h] = m_irq[h] | ctx_irq[c];
                    else                                        s_irq[h] = s_irq[h] | ctx_irq[c];
                end
            end
        end
    end

    // R5
    quiet_ctx_quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_irq == '0) |-> (m_irq == '0 && s_irq == '0));
endmodule

// File: rtl/irq_claim_arbiter.sv
// Module: top of the interrupt claim arbiter.
// Holds source and context state, runs one selector per context, returns the
// addressed context's winner on claim and routes requests to hart lines.
// Assumes NCTX >= 2 and a decoder outside drives the strobes one per cycle.
module irq_claim_arbiter #(
    parameter int          NSRC      = 40,
    parameter int          NCTX      = 4,
    parameter int          PRIO_W    = 3,
    parameter int          NHART     = 2,
    parameter int          HART_BASE = 2,
    parameter int          CTX_HART [NCTX] = '{2, 2, 3, 3},
    parameter logic [NCTX-1:0] CTX_MODE = 4'b0101,
    localparam int         IDW   = $clog2(NSRC),
    localparam int         CTXW  = $clog2(NCTX),
    localparam int         WORDS = irq_arb_pkg::words_for(NSRC),
    localparam int         WDW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_level,
    input  logic              prio_we,
    input  logic [IDW-1:0]    prio_src,
    input  logic [PRIO_W-1:0] prio_val,
    input  logic              thr_we,
    input  logic [CTXW-1:0]   thr_ctx,
    input  logic [PRIO_W-1:0] thr_val,
    input  logic              en_we,
    input  logic [CTXW-1:0]   en_ctx,
    input  logic [WDW-1:0]    en_word,
    input  logic [31:0]       en_data,
    input  logic              claim_req,
    input  logic [CTXW-1:0]   claim_ctx,
    output logic [IDW-1:0]    claim_id,
    input  logic              done_we,
    input  logic [31:0]       done_id,
    output logic [NCTX-1:0]   ctx_irq,
    output logic [NHART-1:0]  m_irq,
    output logic [NHART-1:0]  s_irq
);
    logic [NSRC-1:0]   pend_q;
    logic [NSRC-1:0]   busy_q;
    logic [PRIO_W-1:0] prio_q [NSRC];
    logic [PRIO_W-1:0] thr_q [NCTX];
    logic [NSRC-1:0]   en_q [NCTX];
    logic [IDW-1:0]    win_ids [NCTX];
    logic              claim_fire;

    irq_src_state #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_src (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .prio_we(prio_we), .prio_src(prio_src), .prio_val(prio_val),
        .claim_fire(claim_fire), .claim_win(claim_id),
        .done_we(done_we), .done_id(done_id),
        .pend_q(pend_q), .busy_q(busy_q), .prio_q(prio_q)
    );

    irq_ctx_cfg #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .CTXW(CTXW), .WDW(WDW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_val(thr_val),
        .en_we(en_we), .en_ctx(en_ctx), .en_word(en_word), .en_data(en_data),
        .thr_q(thr_q), .en_q(en_q)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irq_ctx_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
            .clk(clk), .rst_n(rst_n),
            .pend(pend_q), .busy(busy_q), .en(en_q[c]), .prio(prio_q),
            .thr(thr_q[c]), .win_id(win_ids[c])
        );
        assign ctx_irq[c] = (win_ids[c] != '0);
    end

    // Claim returns the addressed context's winner; a zero ID claims nothing.
    assign claim_id   = win_ids[claim_ctx];
    assign claim_fire = claim_req && (claim_id != '0);

    irq_route #(.NCTX(NCTX), .NHART(NHART), .HART_BASE(HART_BASE),
                .CTX_HART(CTX_HART), .CTX_MODE(CTX_MODE)) u_route (
        .clk(clk), .rst_n(rst_n), .ctx_irq(ctx_irq), .m_irq(m_irq), .s_irq(s_irq)
    );

    // R3
    claim_nonzero_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_id != '0) |-> ctx_irq[claim_ctx]);
endmodule

// File: tb/tb_irq_claim_arbiter.sv
`timescale 1ns/1ps
module tb_irq_claim_arbiter;
    localparam int NSRC = 40, NCTX = 4, PRIO_W = 3, NHART = 2, HB = 2;
    localparam int HART [NCTX] = '{2, 2, 3, 3};
    localparam logic [NCTX-1:0] MODE = 4'b0101;

    logic clk = 0, rst_n = 0;
    logic [NSRC-1:0] src_level = '0;
    logic prio_we = 0, thr_we = 0, en_we = 0, claim_req = 0, done_we = 0;
    logic [5:0] prio_src = '0;
    logic [PRIO_W-1:0] prio_val = '0, thr_val = '0;
    logic [1:0] thr_ctx = '0, en_ctx = '0, claim_ctx = '0;
    logic [0:0] en_word = '0;
    logic [31:0] en_data = '0, done_id = '0;
    logic [5:0] claim_id;
    logic [NCTX-1:0] ctx_irq;
    logic [NHART-1:0] m_irq, s_irq;

    int checks = 0, failures = 0;
    int mprio [NSRC];
    int mthr [NCTX];
    logic [NSRC-1:0] men [NCTX];
    logic [NSRC-1:0] mlev = '0, mbusy = '0;

    always #5 clk = ~clk;

    irq_claim_arbiter dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected winner per the R1/R2/R3 rules.
    function automatic int exp_win(input int c);
        int best = mthr[c];
        int id = 0;
        for (int i = 1; i < NSRC; i++)
            if (mlev[i] && !mbusy[i] && men[c][i] && mprio[i] > best) begin
                best = mprio[i]; id = i;
            end
        return id;
    endfunction

    task automatic check_all(input string req);
        logic [NHART-1:0] em = '0, es = '0;
        for (int c = 0; c < NCTX; c++) begin
            int w = exp_win(c);
            claim_ctx = 2'(c);
            #1;
            chk(req, int'(claim_id), w);
            chk("R5", int'(ctx_irq[c]), int'(w != 0));
            if (w != 0) begin
                if (MODE[c]) em[HART[c] - HB] = 1'b1;
                else         es[HART[c] - HB] = 1'b1;
            end
        end
        chk("R5", int'(m_irq), int'(em));
        chk("R5", int'(s_irq), int'(es));
    endtask

    task automatic wr_prio(input int s, input int v);
        prio_we = 1; prio_src = 6'(s); prio_val = 3'(v);
        @(negedge clk); prio_we = 0;
        if (s < NSRC) mprio[s] = v;
    endtask

    task automatic wr_thr(input int c, input int v);
        thr_we = 1; thr_ctx = 2'(c); thr_val = 3'(v);
        @(negedge clk); thr_we = 0; mthr[c] = v;
    endtask

    task automatic wr_en(input int c, input int w, input logic [31:0] d);
        en_we = 1; en_ctx = 2'(c); en_word = 1'(w); en_data = d;
        @(negedge clk); en_we = 0;
        for (int b = 0; b < 32; b++) if (32 * w + b < NSRC) men[c][32 * w + b] = d[b];
    endtask

    task automatic set_lev(input logic [NSRC-1:0] v);
        src_level = v; @(negedge clk); mlev = v; mlev[0] = 1'b0;
    endtask

    task automatic claim(input int c);
        int w = exp_win(c);
        claim_ctx = 2'(c); claim_req = 1; #1;
        chk("R6", int'(claim_id), w);
        @(negedge clk); claim_req = 0;
        if (w != 0) mbusy[w] = 1'b1;
    endtask

    task automatic complete(input int v);
        done_we = 1; done_id = 32'(v);
        @(negedge clk); done_we = 0;
        if (v < NSRC) mbusy[v] = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NSRC; i++) mprio[i] = 0;
        for (int c = 0; c < NCTX; c++) begin mthr[c] = 0; men[c] = '0; end
        src_level = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: state cleared, all IDs and lines zero even with levels high
        mlev = '1; mlev[0] = 1'b0;
        check_all("R8");

        // R2: priority equal to threshold never wins; one above does
        wr_prio(5, 3); wr_en(0, 0, 32'h20); wr_thr(0, 3);
        set_lev(40'h20);
        check_all("R2");
        wr_thr(0, 2); check_all("R2");
        // R4: level low clears pending
        set_lev('0); check_all("R4");
        set_lev(40'h20); check_all("R4");

        // R3 tie across words; R9 word 1 bit 1 is source 33
        wr_prio(7, 4); wr_prio(33, 4);
        wr_en(1, 0, 32'h80); wr_en(1, 1, 32'hFFFF_FFFF);
        set_lev((40'd1 << 33) | (40'd1 << 7) | 40'h1);
        check_all("R3");
        wr_prio(33, 5); check_all("R9");
        // R10: write to nonexistent source ignored
        wr_prio(45, 7); check_all("R10");

        // R6 claim then R7 completion rules
        claim(1); check_all("R6");
        complete(40); check_all("R7");
        complete(63); check_all("R7");
        complete(33); check_all("R7");
        claim(1); claim(1); claim(1); check_all("R3");
        complete(7); complete(33); check_all("R7");

        // R1/R5 sweep of random configurations
        for (int it = 0; it < 60; it++) begin
            for (int s = 1; s < NSRC; s++) wr_prio(s, int'($urandom_range(0, 7)));
            for (int c = 0; c < NCTX; c++) begin
                wr_thr(c, int'($urandom_range(0, 3)));
                wr_en(c, 0, $urandom);
                wr_en(c, 1, $urandom);
            end
            set_lev({8'($urandom), 32'($urandom)});
            check_all("R1");
            begin
                int c = int'($urandom_range(0, NCTX - 1));
                int w = exp_win(c);
                claim(c); check_all("R6");
                complete(w + NSRC); check_all("R7");
                complete(w); check_all("R7");
            end
        end
        finish_run();
    end
endmodule